// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register Block

This block is the register front end of an 8-bit indexed-colour display controller. A host reaches it through a simple word-wide bus: one address, a write strobe with write data, and a read strobe. Read data comes back one cycle later with a valid flag. The block holds the following state:

- the visible width and height;
- a control word that carries forced blanking, cursor suppression and a pixel-depth code;
- the frame start address and the cursor position;
- three lookup tables: a 256-entry colour map, a 3-entry cursor colour map and a 512-word cursor shape store.

The pixel pipeline reads all of this state directly. The scalar values are outputs of the block. Each of the three tables has its own index input and data output on the pixel side, separate from the bus.

Sizes on the bus are in scaled units. The horizontal size is counted in groups of four pixels, and the vertical size in half-lines. The block converts both to pixels and lines internally. All tables sit on an 8-byte address stride.

The display pipeline pulses a frame-done input, which raises an interrupt line. Any bus write lowers that line again, whatever its address. A write to the reset address returns every register and table to zero. Writes to the video timing addresses are taken and thrown away, because timing generation lives elsewhere.

Top module: `fbctl_regs`

## Requirements
- R1: A write to offset 0x118 sets width_px to the written value times 4, truncated to the width port. A read of 0x118 returns width_px divided by 4.
- R2: A write to offset 0x150 sets height_ln to the written value divided by 2, rounded down. A read of 0x150 returns height_ln times 2, so writing an odd value reads back one less.
- R3: Offset 0x300 holds a 32-bit control word that reads back unchanged. blank_force follows bit 10 and cursor_off follows bit 23. depth_bpp decodes bits 22:20 as follows: code 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0.
- R4: A write to 0x800 + 8·i (i from 0 to 255) stores colour-map entry i. The entry packs red in bits 23:16, green in 15:8 and blue in 7:0, and the upper 8 bits are dropped. The entry appears on pix_pal_rgb when pix_pal_idx equals i, and a bus read of that address returns it zero-extended.
- R5: Addresses 0x508, 0x510 and 0x518 hold cursor colours 0, 1 and 2, packed the same way as R4. Each colour is readable over the bus and appears on pix_cpal_rgb for pix_cpal_idx 0, 1 and 2. An index of 3 gives zero.
- R6: A write to 0x1000 + 8·i (i from 0 to 511) stores the low 16 bits as cursor shape word i. The word appears on pix_pat_word when pix_pat_idx equals i, and a bus read returns it zero-extended.
- R7: A write to 0x400 sets top_addr and a write to 0x638 sets cursor_pos, each with all 32 bits. Bus reads of both addresses return zero.
- R8: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170, 0x200, and to any unmapped address, change no state. Reads of these addresses return zero.
- R9: A write to offset 0x100000 clears the following at the next edge: width, height, the control word, the frame start, the cursor position, every entry of all three tables, and the interrupt.
- R10: irq goes low at the edge after any write. Otherwise it goes high at the edge after a frame_done pulse and holds its value. A write in the same cycle as frame_done wins, and irq goes low.
- R11: A read strobe in cycle n gives rd_valid high and rdata in cycle n+1. rdata shows the state as it was before any write in cycle n. When rd_valid is low, rdata is zero.
- R12: After rst_n is asserted, all registers, all table entries, irq and rd_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| frame_done | input | 1 | End-of-frame pulse from the pipeline |
| irq | output | 1 | Frame interrupt |
| width_px | output | DIM_W | Visible width in pixels |
| height_ln | output | DIM_W | Visible height in lines |
| ctrl_word | output | 32 | Control word |
| blank_force | output | 1 | Forced blanking request |
| cursor_off | output | 1 | Cursor suppressed |
| depth_bpp | output | 5 | Decoded pixel depth in bits |
| top_addr | output | 32 | Frame start address |
| cursor_pos | output | 32 | Cursor position word |
| pix_pal_idx | input | log2(PAL_DEPTH) | Pixel-side colour-map index |
| pix_pal_rgb | output | 24 | Colour-map entry |
| pix_cpal_idx | input | 2 | Pixel-side cursor colour index |
| pix_cpal_rgb | output | 24 | Cursor colour entry |
| pix_pat_idx | input | log2(PAT_DEPTH) | Pixel-side cursor shape index |
| pix_pat_word | output | 16 | Cursor shape word |

## Verification
The assertions assume that the address is stable and meaningful whenever a strobe is high, and that frame_done is a plain level sampled at each edge. The bench drives every input at the falling edge and returns the strobes to zero after one cycle, so each access covers exactly one rising edge. The assertions on ignored writes assume that a write below 0x200 cannot touch a table. This holds because the table bases are fixed above that range. The same-cycle read and write test is the only stimulus that overlaps two accesses, and it targets a single register on purpose.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    // Fixed register offsets (byte addresses)
    localparam logic [31:0] OFF_HDISP  = 32'h0000_0118;
    localparam logic [31:0] OFF_VDISP  = 32'h0000_0150;
    localparam logic [31:0] OFF_CTRL   = 32'h0000_0300;
    localparam logic [31:0] OFF_TOP    = 32'h0000_0400;
    localparam logic [31:0] OFF_CPOS   = 32'h0000_0638;
    localparam logic [31:0] OFF_SRST   = 32'h0010_0000;

    // Table bases; every table uses an 8-byte stride
    localparam logic [31:0] BASE_CPAL  = 32'h0000_0508;
    localparam logic [31:0] BASE_PAL   = 32'h0000_0800;
    localparam logic [31:0] BASE_PAT   = 32'h0000_1000;
    localparam int          STRIDE_LG  = 3;

    // Control word fields
    localparam int CTRL_BLANK_BIT = 10;
    localparam int CTRL_NOCUR_BIT = 23;
    localparam int CTRL_DEPTH_LSB = 20;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_HDISP,
        RG_VDISP,
        RG_CTRL,
        RG_TOP,
        RG_CPOS,
        RG_TIMING,
        RG_SRST,
        RG_PAL,
        RG_CPAL,
        RG_PAT
    } region_e;

    function automatic logic [4:0] depth_of(input logic [2:0] code);
        logic [4:0] bpp;
        case (code)
            3'd0:    bpp = 5'd1;
            3'd1:    bpp = 5'd2;
            3'd2:    bpp = 5'd4;
            3'd3:    bpp = 5'd8;
            3'd4:    bpp = 5'd15;
            3'd5:    bpp = 5'd16;
            default: bpp = 5'd0;
        endcase
        return bpp;
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int PAL_DEPTH  = 256,
    parameter int CPAL_DEPTH = 3,
    parameter int PAT_DEPTH  = 512,
    localparam int PAL_IW    = $clog2(PAL_DEPTH),
    localparam int CPAL_IW   = $clog2(CPAL_DEPTH),
    localparam int PAT_IW    = $clog2(PAT_DEPTH)
) (
    input  logic [ADDR_W-1:0]  addr,
    output region_e            region,
    output logic [PAL_IW-1:0]  pal_idx,
    output logic [CPAL_IW-1:0] cpal_idx,
    output logic [PAT_IW-1:0]  pat_idx
);

    localparam logic [31:0] PAL_END  = BASE_PAL  + 32'(PAL_DEPTH  << STRIDE_LG);
    localparam logic [31:0] CPAL_END = BASE_CPAL + 32'(CPAL_DEPTH << STRIDE_LG);
    localparam logic [31:0] PAT_END  = BASE_PAT  + 32'(PAT_DEPTH  << STRIDE_LG);

    logic [31:0] a32;
    logic [31:0] pal_off, cpal_off, pat_off;

    assign a32      = 32'(addr);
    assign pal_off  = (a32 - BASE_PAL)  >> STRIDE_LG;
    assign cpal_off = (a32 - BASE_CPAL) >> STRIDE_LG;
    assign pat_off  = (a32 - BASE_PAT)  >> STRIDE_LG;

    assign pal_idx  = PAL_IW'(pal_off);
    assign cpal_idx = CPAL_IW'(cpal_off);
    assign pat_idx  = PAT_IW'(pat_off);

    always_comb begin
        if (a32 >= BASE_PAL && a32 < PAL_END) begin
            region = RG_PAL;
        end else if (a32 >= BASE_PAT && a32 < PAT_END) begin
            region = RG_PAT;
        end else if (a32 >= BASE_CPAL && a32 < CPAL_END) begin
            region = RG_CPAL;
        end else begin
            case (a32)
                OFF_HDISP: region = RG_HDISP;
                OFF_VDISP: region = RG_VDISP;
                OFF_CTRL:  region = RG_CTRL;
                OFF_TOP:   region = RG_TOP;
                OFF_CPOS:  region = RG_CPOS;
                OFF_SRST:  region = RG_SRST;
                32'h000, 32'h108, 32'h110, 32'h120, 32'h128,
                32'h130, 32'h138, 32'h140, 32'h148, 32'h158,
                32'h160, 32'h168, 32'h170, 32'h200:
                           region = RG_TIMING;
                default:   region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fbctl_table.sv
module fbctl_table #(
    parameter int  DEPTH = 256,
    parameter int  WIDTH = 24,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    ridx_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [IW-1:0]    ridx_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (we && (32'(widx) < DEPTH)) begin
            mem_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_a = (32'(ridx_a) < DEPTH) ? mem_q[ridx_a] : '0;
    assign rdata_b = (32'(ridx_b) < DEPTH) ? mem_q[ridx_b] : '0;

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int DIM_W      = 16,
    parameter int PAL_DEPTH  = 256,
    parameter int CPAL_DEPTH = 3,
    parameter int PAT_DEPTH  = 512,
    parameter int RGB_W      = 24,
    parameter int PAT_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    output logic                         rd_valid,
    input  logic                         frame_done,
    output logic                         irq,
    output logic [DIM_W-1:0]             width_px,
    output logic [DIM_W-1:0]             height_ln,
    output logic [31:0]                  ctrl_word,
    output logic                         blank_force,
    output logic                         cursor_off,
    output logic [4:0]                   depth_bpp,
    output logic [31:0]                  top_addr,
    output logic [31:0]                  cursor_pos,
    input  logic [$clog2(PAL_DEPTH)-1:0] pix_pal_idx,
    output logic [RGB_W-1:0]             pix_pal_rgb,
    input  logic [$clog2(CPAL_DEPTH)-1:0] pix_cpal_idx,
    output logic [RGB_W-1:0]             pix_cpal_rgb,
    input  logic [$clog2(PAT_DEPTH)-1:0] pix_pat_idx,
    output logic [PAT_W-1:0]             pix_pat_word
);

    localparam int PAL_IW  = $clog2(PAL_DEPTH);
    localparam int CPAL_IW = $clog2(CPAL_DEPTH);
    localparam int PAT_IW  = $clog2(PAT_DEPTH);

    typedef struct packed {
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
        logic [31:0]      ctrl;
        logic [31:0]      top;
        logic [31:0]      cpos;
        logic             irq;
        logic             rd_valid;
        logic [31:0]      rdata;
    } state_t;

    state_t st_d, st_q;

    region_e            rgn;
    logic [PAL_IW-1:0]  pal_widx;
    logic [CPAL_IW-1:0] cpal_widx;
    logic [PAT_IW-1:0]  pat_widx;
    logic [RGB_W-1:0]   pal_bus_rd, cpal_bus_rd;
    logic [PAT_W-1:0]   pat_bus_rd;
    logic               soft_rst;

    fbctl_decode #(
        .ADDR_W     (ADDR_W),
        .PAL_DEPTH  (PAL_DEPTH),
        .CPAL_DEPTH (CPAL_DEPTH),
        .PAT_DEPTH  (PAT_DEPTH)
    ) u_decode (
        .addr     (addr),
        .region   (rgn),
        .pal_idx  (pal_widx),
        .cpal_idx (cpal_widx),
        .pat_idx  (pat_widx)
    );

    assign soft_rst = wr_en && (rgn == RG_SRST);

    fbctl_table #(.DEPTH(PAL_DEPTH), .WIDTH(RGB_W)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .we      (wr_en && (rgn == RG_PAL)),
        .widx    (pal_widx),
        .wdata   (wdata[RGB_W-1:0]),
        .ridx_a  (pal_widx),
        .rdata_a (pal_bus_rd),
        .ridx_b  (pix_pal_idx),
        .rdata_b (pix_pal_rgb)
    );

    fbctl_table #(.DEPTH(CPAL_DEPTH), .WIDTH(RGB_W)) u_cpal (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .we      (wr_en && (rgn == RG_CPAL)),
        .widx    (cpal_widx),
        .wdata   (wdata[RGB_W-1:0]),
        .ridx_a  (cpal_widx),
        .rdata_a (cpal_bus_rd),
        .ridx_b  (pix_cpal_idx),
        .rdata_b (pix_cpal_rgb)
    );

    fbctl_table #(.DEPTH(PAT_DEPTH), .WIDTH(PAT_W)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .we      (wr_en && (rgn == RG_PAT)),
        .widx    (pat_widx),
        .wdata   (wdata[PAT_W-1:0]),
        .ridx_a  (pat_widx),
        .rdata_a (pat_bus_rd),
        .ridx_b  (pix_pat_idx),
        .rdata_b (pix_pat_word)
    );

    always_comb begin
        logic [31:0] rd_val;
        st_d = st_q;

        // read side sees pre-write state (R11)
        case (rgn)
            RG_HDISP: rd_val = 32'(st_q.width >> 2);
            RG_VDISP: rd_val = 32'({st_q.height, 1'b0});
            RG_CTRL:  rd_val = st_q.ctrl;
            RG_PAL:   rd_val = 32'(pal_bus_rd);
            RG_CPAL:  rd_val = 32'(cpal_bus_rd);
            RG_PAT:   rd_val = 32'(pat_bus_rd);
            default:  rd_val = '0;
        endcase
        st_d.rd_valid = rd_en;
        st_d.rdata    = rd_en ? rd_val : '0;

        if (frame_done) st_d.irq = 1'b1;

        if (wr_en) begin
            st_d.irq = 1'b0;
            case (rgn)
                RG_HDISP: st_d.width  = DIM_W'({wdata, 2'b00});
                RG_VDISP: st_d.height = DIM_W'(wdata >> 1);
                RG_CTRL:  st_d.ctrl   = wdata;
                RG_TOP:   st_d.top    = wdata;
                RG_CPOS:  st_d.cpos   = wdata;
                RG_SRST: begin
                    st_d.width  = '0;
                    st_d.height = '0;
                    st_d.ctrl   = '0;
                    st_d.top    = '0;
                    st_d.cpos   = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata       = st_q.rdata;
    assign rd_valid    = st_q.rd_valid;
    assign irq         = st_q.irq;
    assign width_px    = st_q.width;
    assign height_ln   = st_q.height;
    assign ctrl_word   = st_q.ctrl;
    assign blank_force = st_q.ctrl[CTRL_BLANK_BIT];
    assign cursor_off  = st_q.ctrl[CTRL_NOCUR_BIT];
    assign depth_bpp   = depth_of(st_q.ctrl[CTRL_DEPTH_LSB +: 3]);
    assign top_addr    = st_q.top;
    assign cursor_pos  = st_q.cpos;

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
    parameter int ADDR_W = 21,
    parameter int DIM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              frame_done,
    input logic              irq,
    input logic              rd_valid,
    input logic [DIM_W-1:0]  width_px,
    input logic [DIM_W-1:0]  height_ln,
    input logic [31:0]       ctrl_word,
    input logic [31:0]       top_addr,
    input logic [31:0]       cursor_pos
);

    logic [31:0] a32;
    logic        low_area;
    assign a32      = 32'(addr);
    assign low_area = (a32 <= 32'h200) && (a32 != 32'h118) && (a32 != 32'h150);

    assert_wr_clears_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);

    assert_frame_sets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !wr_en) |=> irq);

    assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !wr_en) |=> $stable(irq));

    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_idle_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_width_scale_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a32 == 32'h118) |=> (width_px == DIM_W'({$past(wdata), 2'b00})));

    assert_height_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a32 == 32'h150) |=> (height_ln == DIM_W'($past(wdata) >> 1)));

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a32 == 32'h0010_0000) |=>
        (width_px == '0 && height_ln == '0 && ctrl_word == '0 &&
         top_addr == '0 && cursor_pos == '0 && !irq));

    assert_low_writes_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && low_area) |=>
        ($stable(width_px) && $stable(height_ln) && $stable(ctrl_word) &&
         $stable(top_addr) && $stable(cursor_pos)));

endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .frame_done (frame_done),
    .irq        (irq),
    .rd_valid   (rd_valid),
    .width_px   (width_px),
    .height_ln  (height_ln),
    .ctrl_word  (ctrl_word),
    .top_addr   (top_addr),
    .cursor_pos (cursor_pos)
);

// File: tb/fbctl_regs_tb.sv
module fbctl_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, frame_done = 1'b0;
    logic [20:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid, irq, blank_force, cursor_off;
    logic [15:0] width_px, height_ln;
    logic [31:0] ctrl_word, top_addr, cursor_pos;
    logic [4:0]  depth_bpp;
    logic [7:0]  pix_pal_idx = '0;
    logic [23:0] pix_pal_rgb;
    logic [1:0]  pix_cpal_idx = '0;
    logic [23:0] pix_cpal_rgb;
    logic [8:0]  pix_pat_idx = '0;
    logic [15:0] pix_pat_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .frame_done(frame_done),
        .irq(irq), .width_px(width_px), .height_ln(height_ln), .ctrl_word(ctrl_word),
        .blank_force(blank_force), .cursor_off(cursor_off), .depth_bpp(depth_bpp),
        .top_addr(top_addr), .cursor_pos(cursor_pos),
        .pix_pal_idx(pix_pal_idx), .pix_pal_rgb(pix_pal_rgb),
        .pix_cpal_idx(pix_cpal_idx), .pix_cpal_rgb(pix_cpal_rgb),
        .pix_pat_idx(pix_pat_idx), .pix_pat_word(pix_pat_word)
    );

    // {req, addr, write data, expected read-back}
    localparam logic [88:0] VEC [NVEC] = '{
        {4'd1,  21'h000118, 32'h0000_0050, 32'h0000_0050},  // R1
        {4'd2,  21'h000150, 32'h0000_03C1, 32'h0000_03C0},  // R2 odd value
        {4'd3,  21'h000300, 32'h00B0_0400, 32'h00B0_0400},  // R3
        {4'd4,  21'h000808, 32'hFF12_3456, 32'h0012_3456},  // R4 entry 1
        {4'd4,  21'h000FF8, 32'h00FF_FFFF, 32'h00FF_FFFF},  // R4 entry 255
        {4'd5,  21'h000510, 32'hAABB_CCDD, 32'h00BB_CCDD},  // R5 entry 1
        {4'd6,  21'h001010, 32'h1234_ABCD, 32'h0000_ABCD},  // R6 word 2
        {4'd6,  21'h001FF8, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R6 word 511
        {4'd7,  21'h000400, 32'hDEAD_0000, 32'h0000_0000},  // R7 top
        {4'd7,  21'h000638, 32'h0004_0010, 32'h0000_0000},  // R7 cursor
        {4'd8,  21'h000108, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 timing
        {4'd8,  21'h000520, 32'h0000_0111, 32'h0000_0000}   // R8 unmapped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [20:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [20:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid;
    endtask

    initial begin
        logic [31:0] rv;
        logic        vv;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 width", 32'(width_px), 0);
        chk("R12 irq/valid", {30'b0, irq, rd_valid}, 0);
        pix_pat_idx = 9'd2;
        #1 chk("R12 pattern", 32'(pix_pat_word), 0);
        rst_n = 1'b1;
        bus_rd(21'h118, rv, vv);
        chk("R12 width read", rv, 0);
        chk("R11 valid", 32'(vv), 1);

        for (int i = 0; i < NVEC; i++) begin
            bus_wr(VEC[i][84:64], VEC[i][63:32]);
            bus_rd(VEC[i][84:64], rv, vv);
            n_chk++;
            if (rv !== VEC[i][31:0] || vv !== 1'b1) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         VEC[i][88:85], i, rv, VEC[i][31:0]);
            end
        end

        // exported values
        chk("R1 width_px", 32'(width_px), 32'h140);
        chk("R2 height_ln", 32'(height_ln), 32'h1E0);
        chk("R3 flags", {29'b0, blank_force, cursor_off, 1'b0}, 32'h6);
        chk("R3 depth 8", 32'(depth_bpp), 8);
        chk("R7 top_addr", top_addr, 32'hDEAD_0000);
        chk("R7 cursor_pos", cursor_pos, 32'h0004_0010);
        pix_pal_idx = 8'd1; pix_cpal_idx = 2'd1; pix_pat_idx = 9'd2;
        #1;
        chk("R4 pixel lookup", 32'(pix_pal_rgb), 32'h12_3456);
        chk("R5 pixel lookup", 32'(pix_cpal_rgb), 32'hBB_CCDD);
        chk("R6 pixel lookup", 32'(pix_pat_word), 32'hABCD);
        pix_cpal_idx = 2'd3;
        #1 chk("R5 index 3", 32'(pix_cpal_rgb), 0);

        // R8: timing writes leave state alone
        bus_wr(21'h170, 32'hFFFF_FFFF);
        bus_wr(21'h000, 32'h1234_5678);
        chk("R8 width kept", 32'(width_px), 32'h140);
        chk("R8 ctrl kept", ctrl_word, 32'h00B0_0400);
        chk("R8 top kept", top_addr, 32'hDEAD_0000);

        // R3: depth decode
        bus_wr(21'h300, 32'h0040_0000);
        chk("R3 depth 15", 32'(depth_bpp), 15);
        bus_wr(21'h300, 32'h0050_0000);
        chk("R3 depth 16", 32'(depth_bpp), 16);
        bus_wr(21'h300, 32'h0060_0000);
        chk("R3 depth code6", 32'(depth_bpp), 0);
        chk("R3 flags clear", {30'b0, blank_force, cursor_off}, 0);

        // R10: interrupt
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R10 set", 32'(irq), 1);
        @(negedge clk);
        chk("R10 hold", 32'(irq), 1);
        bus_wr(21'h004, 32'h0);
        chk("R10 cleared by write", 32'(irq), 0);
        @(negedge clk); frame_done = 1'b1; wr_en = 1'b1; addr = 21'h108; wdata = '0;
        @(negedge clk); frame_done = 1'b0; wr_en = 1'b0;
        chk("R10 write wins", 32'(irq), 0);

        // R11: read and write in one cycle returns old value
        @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = 21'h118; wdata = 32'h20;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        chk("R11 old data", rdata, 32'h50);
        chk("R1 new width", 32'(width_px), 32'h80);
        @(negedge clk);
        chk("R11 idle data", {rdata[30:0], rd_valid}, 0);

        // R9: soft reset
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        bus_wr(21'h100000, 32'h0);
        chk("R9 irq", 32'(irq), 0);
        chk("R9 scalars", width_px | height_ln | 16'(ctrl_word | top_addr | cursor_pos), 0);
        chk("R9 ctrl", ctrl_word | top_addr | cursor_pos, 0);
        pix_pal_idx = 8'd1; pix_cpal_idx = 2'd1; pix_pat_idx = 9'd511;
        #1;
        chk("R9 tables", 32'(pix_pal_rgb | pix_cpal_rgb | 24'(pix_pat_word)), 0);
        bus_rd(21'hFF8, rv, vv);
        chk("R9 palette read", rv, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule